// File: doc/BRIEF.md
# PTP Time-of-Day Counter

This block keeps a time-of-day value for precision time protocol work, made of a seconds word and a sub-second word, advanced by the reference clock. Each cycle the sub-second word grows by a programmable increment. In coarse mode the increment is added on every cycle. In fine mode a 32-bit accumulator adds a frequency addend on every cycle, and the increment is applied only on the cycles where that sum carries out. Software can then trim the rate by changing the addend.

The sub-second word wraps at one of two limits, picked by a format input. In decimal format it wraps at 10^9, so each count is 1 ns. In binary format it wraps at 2^31, so each count is about 0.466 ns. Each wrap adds one second. Three one-shot commands change the state. A load command copies the staged time into the counter. A step command adds the staged time to the counter, or subtracts it using a complement encoding. A reload command copies the staged addend into the live addend. Each command bit reads back as pending until it has been carried out.

Top module: `ptp_tod_counter`

## Requirements
- R1: While rst_ni is low and after its release, sec_o, sub_o, pend_o, inc_o and addend_o are all zero.
- R2: In coarse mode (fine_i=0) with en_i=1 and no command executing, each clock edge adds inc_o to sub_o.
- R3: In fine mode (fine_i=1) with en_i=1, each edge adds addend_o to a 32-bit accumulator that starts at zero. inc_o is added to sub_o only on edges where that sum is 2^32 or more, and the accumulator keeps the low 32 bits.
- R4: With dec_i=1, a sub-second sum of 10^9 or more is reduced by 10^9, and sec_o is incremented by one in the same edge.
- R5: With dec_i=0, a sub-second sum of 2^31 or more is reduced by 2^31, and sec_o is incremented by one in the same edge.
- R6: An edge with inc_wr_i=1 stores inc_i into inc_o. Values above 255 are stored as 255. The new increment is first used on the following edge.
- R7: A write (cmd_wr_i=1) with cmd_init_i=1 sets pend_o[0] at that edge. At the next edge sec_o takes sec_upd_i, sub_o takes sub_upd_i[30:0], and pend_o[0] clears.
- R8: A step command with sub_upd_i[31]=0 (pend_o[1]) sets sub_o to sub_o+sub_upd_i[30:0], with the wrap of R4/R5. sec_o becomes sec_o+sec_upd_i+wrap, modulo 2^32. The time does not also advance on that edge.
- R9: A step command with sub_upd_i[31]=1 is a subtraction. Software supplies 2^32 minus the seconds and the wrap limit minus the sub-seconds. sub_o is computed as in R8. sec_o becomes sec_o+sec_upd_i, minus one when the sub-second sum did not wrap, modulo 2^32.
- R10: A reload command (pend_o[2]) copies addend_stage_i into addend_o at the next edge. The time advances normally on that edge, using the old addend.
- R11: If one write sets several command bits, only the highest-priority one is executed: load before step before reload. The others are cleared on the same edge without effect.
- R12: While en_i=0, sec_o, sub_o and the accumulator hold, command writes are ignored, and pending bits are cleared without effect.
- R13: A command write that arrives while any pend_o bit is set is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Master enable for advance and commands |
| fine_i | input | 1 | 1: accumulator-gated advance, 0: advance every cycle |
| dec_i | input | 1 | 1: decimal wrap at 10^9, 0: binary wrap at 2^31 |
| inc_wr_i | input | 1 | Write strobe for the sub-second increment |
| inc_i | input | 16 | Increment value, saturated to 255 |
| sec_upd_i | input | 32 | Staged seconds for load and step |
| sub_upd_i | input | 32 | Staged sub-seconds; bit 31 selects subtraction for step |
| addend_stage_i | input | 32 | Staged frequency addend |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_init_i | input | 1 | Load command bit |
| cmd_step_i | input | 1 | Step command bit |
| cmd_reload_i | input | 1 | Addend reload command bit |
| pend_o | output | 3 | Pending bits {reload, step, load} |
| sec_o | output | 32 | Seconds |
| sub_o | output | 32 | Sub-seconds |
| inc_o | output | 8 | Live increment |
| addend_o | output | 32 | Live addend |

## Verification
The bench drives the sub-second word to just below each wrap limit. A design with an off-by-one compare would either skip the seconds carry or emit a sub-second value equal to the limit. Subtraction steps are applied both where the sub-second part borrows and where it does not, so a design that ignores the missing carry ends one second late. The bench also issues multi-bit writes, back-to-back writes and writes while disabled. Wrong priority, a second command executing, or commands running while disabled would each show up as a time or addend that differs from the model. In fine mode the bench uses one addend that carries every fourth cycle and one that never carries, so a design that always applies the increment, or that skips the carry gating, diverges within a few cycles.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  typedef enum logic [1:0] {OP_ADV, OP_INIT, OP_STEP} time_op_e;
  typedef struct packed {
    logic reload;
    logic step;
    logic init;
  } cmd_t;
endpackage

// File: rtl/ptp_cmd_ctrl.sv
module ptp_cmd_ctrl
  import ptp_tod_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     cmd_wr_i,
  input  cmd_t     cmd_i,
  output cmd_t     pend_o,
  output time_op_e op_o,
  output logic     reload_o
);
  cmd_t pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pend_q <= '0;
    else if (!en_i)           pend_q <= '0;
    else if (pend_q != '0)    pend_q <= '0;  // executed or discarded
    else if (cmd_wr_i)        pend_q <= cmd_i;
  end

  // priority: init > step > reload
  always_comb begin
    op_o     = OP_ADV;
    reload_o = 1'b0;
    if (en_i) begin
      if (pend_q.init)      op_o = OP_INIT;
      else if (pend_q.step) op_o = OP_STEP;
      else                  reload_o = pend_q.reload;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/ptp_rate_gen.sv
module ptp_rate_gen #(
  parameter int ACC_W    = 32,
  parameter int INC_W    = 8,
  parameter int INC_IN_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                fine_i,
  input  logic                inc_wr_i,
  input  logic [INC_IN_W-1:0] inc_i,
  input  logic                reload_i,
  input  logic [ACC_W-1:0]    addend_stage_i,
  output logic [INC_W-1:0]    step_o,
  output logic [INC_W-1:0]    inc_o,
  output logic [ACC_W-1:0]    addend_o
);
  logic [INC_W-1:0] inc_q, inc_d;
  logic [ACC_W-1:0] addend_q, acc_q;
  logic [ACC_W:0]   acc_sum;

  generate
    if (INC_IN_W > INC_W) begin : g_sat
      localparam logic [INC_W-1:0] IncMax = '1;
      always_comb
        inc_d = (inc_i > INC_IN_W'(IncMax)) ? IncMax : inc_i[INC_W-1:0];
    end else begin : g_direct
      always_comb inc_d = INC_W'(inc_i);
    end
  endgenerate

  assign acc_sum = {1'b0, acc_q} + {1'b0, addend_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inc_q    <= '0;
      addend_q <= '0;
      acc_q    <= '0;
    end else begin
      if (inc_wr_i)       inc_q    <= inc_d;
      if (reload_i)       addend_q <= addend_stage_i;
      if (en_i && fine_i) acc_q    <= acc_sum[ACC_W-1:0];
    end
  end

  assign step_o   = (en_i && (!fine_i || acc_sum[ACC_W])) ? inc_q : '0;
  assign inc_o    = inc_q;
  assign addend_o = addend_q;
endmodule

// File: rtl/ptp_time_core.sv
module ptp_time_core
  import ptp_tod_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int SUB_W = 32,
  parameter int INC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             dec_i,
  input  time_op_e         op_i,
  input  logic [INC_W-1:0] step_i,
  input  logic [SEC_W-1:0] sec_upd_i,
  input  logic [SUB_W-1:0] sub_upd_i,
  output logic [SEC_W-1:0] sec_o,
  output logic [SUB_W-1:0] sub_o
);
  localparam int FW = SUB_W - 1;  // payload bits; top bit is the subtract flag
  localparam logic [SUB_W:0] DecLim = (SUB_W+1)'(1_000_000_000);
  localparam logic [SUB_W:0] BinLim = (SUB_W+1)'(1) << FW;

  logic [SEC_W-1:0] sec_q, sec_step;
  logic [SUB_W-1:0] sub_q;
  logic [SUB_W:0]   lim, operand, sum, sum_wr;
  logic             wrap;

  assign lim     = dec_i ? DecLim : BinLim;
  assign operand = (op_i == OP_STEP) ? {2'b00, sub_upd_i[FW-1:0]} : (SUB_W+1)'(step_i);
  assign sum     = {1'b0, sub_q} + operand;
  assign wrap    = (sum >= lim);
  assign sum_wr  = wrap ? sum - lim : sum;

  // subtraction: missing wrap means a borrow from the seconds
  assign sec_step = sub_upd_i[SUB_W-1] ? sec_q + sec_upd_i - SEC_W'(!wrap)
                                       : sec_q + sec_upd_i + SEC_W'(wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      sub_q <= '0;
    end else begin
      unique case (op_i)
        OP_INIT: begin
          sec_q <= sec_upd_i;
          sub_q <= {1'b0, sub_upd_i[FW-1:0]};
        end
        OP_STEP: begin
          sec_q <= sec_step;
          sub_q <= sum_wr[SUB_W-1:0];
        end
        default: if (en_i) begin
          sec_q <= sec_q + SEC_W'(wrap);
          sub_q <= sum_wr[SUB_W-1:0];
        end
      endcase
    end
  end

  assign sec_o = sec_q;
  assign sub_o = sub_q;
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
  import ptp_tod_pkg::*;
#(
  parameter int SEC_W    = 32,
  parameter int SUB_W    = 32,
  parameter int ACC_W    = 32,
  parameter int INC_W    = 8,
  parameter int INC_IN_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                fine_i,
  input  logic                dec_i,
  input  logic                inc_wr_i,
  input  logic [INC_IN_W-1:0] inc_i,
  input  logic [SEC_W-1:0]    sec_upd_i,
  input  logic [SUB_W-1:0]    sub_upd_i,
  input  logic [ACC_W-1:0]    addend_stage_i,
  input  logic                cmd_wr_i,
  input  logic                cmd_init_i,
  input  logic                cmd_step_i,
  input  logic                cmd_reload_i,
  output logic [2:0]          pend_o,
  output logic [SEC_W-1:0]    sec_o,
  output logic [SUB_W-1:0]    sub_o,
  output logic [INC_W-1:0]    inc_o,
  output logic [ACC_W-1:0]    addend_o
);
  cmd_t             cmd, pend;
  time_op_e         op;
  logic             reload;
  logic [INC_W-1:0] step;

  assign cmd = '{reload: cmd_reload_i, step: cmd_step_i, init: cmd_init_i};

  ptp_cmd_ctrl u_cmd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .cmd_wr_i(cmd_wr_i),
    .cmd_i   (cmd),
    .pend_o  (pend),
    .op_o    (op),
    .reload_o(reload)
  );

  ptp_rate_gen #(
    .ACC_W   (ACC_W),
    .INC_W   (INC_W),
    .INC_IN_W(INC_IN_W)
  ) u_rate (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (en_i),
    .fine_i        (fine_i),
    .inc_wr_i      (inc_wr_i),
    .inc_i         (inc_i),
    .reload_i      (reload),
    .addend_stage_i(addend_stage_i),
    .step_o        (step),
    .inc_o         (inc_o),
    .addend_o      (addend_o)
  );

  ptp_time_core #(
    .SEC_W(SEC_W),
    .SUB_W(SUB_W),
    .INC_W(INC_W)
  ) u_time (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .dec_i    (dec_i),
    .op_i     (op),
    .step_i   (step),
    .sec_upd_i(sec_upd_i),
    .sub_upd_i(sub_upd_i),
    .sec_o    (sec_o),
    .sub_o    (sub_o)
  );

  assign pend_o = pend;
endmodule

// File: rtl/ptp_tod_counter_chk.sv
module ptp_tod_counter_chk #(
  parameter int SEC_W    = 32,
  parameter int SUB_W    = 32,
  parameter int ACC_W    = 32,
  parameter int INC_W    = 8,
  parameter int INC_IN_W = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                en_i,
  input logic                inc_wr_i,
  input logic [INC_IN_W-1:0] inc_i,
  input logic [SEC_W-1:0]    sec_upd_i,
  input logic [ACC_W-1:0]    addend_stage_i,
  input logic [2:0]          pend_o,
  input logic [SEC_W-1:0]    sec_o,
  input logic [SUB_W-1:0]    sub_o,
  input logic [INC_W-1:0]    inc_o,
  input logic [ACC_W-1:0]    addend_o
);
  localparam logic [INC_W-1:0] IncMax = '1;

  // R7
  pend_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o != 3'b000) |=> (pend_o == 3'b000));

  // R7
  init_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && pend_o[0]) |=> (sec_o == $past(sec_upd_i)));

  // R10
  addend_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && pend_o == 3'b100) |=> (addend_o == $past(addend_stage_i)));

  // R12
  disabled_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(sec_o) && $stable(sub_o) && pend_o == 3'b000));

  // R4
  sec_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && pend_o == 3'b000) |=> (sec_o == $past(sec_o) || sec_o == $past(sec_o) + 1'b1));

  // R6
  inc_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_wr_i && inc_i > INC_IN_W'(IncMax)) |=> (inc_o == IncMax));
endmodule

bind ptp_tod_counter ptp_tod_counter_chk #(
  .SEC_W(SEC_W), .SUB_W(SUB_W), .ACC_W(ACC_W), .INC_W(INC_W), .INC_IN_W(INC_IN_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .inc_wr_i(inc_wr_i), .inc_i(inc_i),
  .sec_upd_i(sec_upd_i), .addend_stage_i(addend_stage_i), .pend_o(pend_o),
  .sec_o(sec_o), .sub_o(sub_o), .inc_o(inc_o), .addend_o(addend_o)
);

// File: tb/ptp_tod_counter_tb_top.sv
module ptp_tod_counter_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0, fine_i = 1'b0, dec_i = 1'b0;
  logic        inc_wr_i = 1'b0;
  logic [15:0] inc_i = '0;
  logic [31:0] sec_upd_i = '0, sub_upd_i = '0, addend_stage_i = '0;
  logic        cmd_wr_i = 1'b0, cmd_init_i = 1'b0, cmd_step_i = 1'b0, cmd_reload_i = 1'b0;
  logic [2:0]  pend_o;
  logic [31:0] sec_o, sub_o, addend_o;
  logic [7:0]  inc_o;

  int    n_vec = 0, n_bad = 0;
  string tag = "R1";
  bit    done = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  ptp_tod_counter dut_i (.*);

  // behavioural reference model
  longint m_sec, m_sub, m_acc, m_add, m_inc;
  bit [2:0] m_pend;
  localparam longint M32 = 64'hFFFF_FFFF;

  always @(posedge clk_i or negedge rst_ni) begin
    longint lim, s, t, amt;
    bit xi, xu, xa, cy, wr;
    if (!rst_ni) begin
      m_sec = 0; m_sub = 0; m_acc = 0; m_add = 0; m_inc = 0; m_pend = 0;
    end else begin
      lim = dec_i ? 64'd1000000000 : 64'd2147483648;
      xi  = en_i && m_pend[0];
      xu  = en_i && m_pend[1] && !m_pend[0];
      xa  = en_i && m_pend[2] && (m_pend[1:0] == 2'b00);
      amt = 0;
      if (en_i) begin
        cy = 1;
        if (fine_i) begin
          t = m_acc + m_add;
          cy = (t > M32);
          m_acc = t & M32;
        end
        if (cy) amt = m_inc;
      end
      if (xi) begin
        m_sec = sec_upd_i;
        m_sub = sub_upd_i & 64'h7FFF_FFFF;
      end else if (xu) begin
        s = m_sub + (sub_upd_i & 64'h7FFF_FFFF);
        wr = (s >= lim);
        if (wr) s = s - lim;
        m_sub = s;
        if (sub_upd_i[31]) m_sec = (m_sec + sec_upd_i - (wr ? 0 : 1)) & M32;
        else               m_sec = (m_sec + sec_upd_i + (wr ? 1 : 0)) & M32;
      end else if (en_i) begin
        s = m_sub + amt;
        if (s >= lim) begin
          s = s - lim;
          m_sec = (m_sec + 1) & M32;
        end
        m_sub = s;
      end
      if (xa) m_add = addend_stage_i;
      if (inc_wr_i) m_inc = (inc_i > 255) ? 255 : inc_i;
      if (!en_i)              m_pend = 0;
      else if (m_pend != 0)   m_pend = 0;
      else if (cmd_wr_i)      m_pend = {cmd_reload_i, cmd_step_i, cmd_init_i};
    end
  end

  task automatic cmp(string what, longint act, longint exp);
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      n_vec++;
      cmp("sec_o", sec_o, m_sec);
      cmp("sub_o", sub_o, m_sub);
      cmp("pend_o", pend_o, m_pend);
      cmp("inc_o", inc_o, m_inc);
      cmp("addend_o", addend_o, m_add);
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic set_inc(int v);
    @(negedge clk_i);
    inc_wr_i = 1'b1; inc_i = 16'(v);
    @(negedge clk_i);
    inc_wr_i = 1'b0;
  endtask

  task automatic cmd(bit i, bit s, bit r);
    @(negedge clk_i);
    cmd_wr_i = 1'b1; cmd_init_i = i; cmd_step_i = s; cmd_reload_i = r;
    @(negedge clk_i);
    cmd_wr_i = 1'b0; cmd_init_i = 0; cmd_step_i = 0; cmd_reload_i = 0;
  endtask

  task automatic summary();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    // R1: reset values
    run(3);
    n_vec++;
    cmp("sec_o", sec_o, 0); cmp("sub_o", sub_o, 0); cmp("pend_o", pend_o, 0);
    cmp("inc_o", inc_o, 0); cmp("addend_o", addend_o, 0);
    rst_ni = 1'b1;
    run(3);
    // R6: saturation
    tag = "R6"; set_inc(1000); run(2);
    en_i = 1'b1; dec_i = 1'b1; run(3);
    // R2: coarse advance
    tag = "R2"; set_inc(10); run(20);
    // R7 then R4: load near decimal wrap
    tag = "R7"; sec_upd_i = 5; sub_upd_i = 999_999_900; cmd(1, 0, 0); run(2);
    tag = "R4"; set_inc(255); run(6);
    // R5: binary wrap
    tag = "R5"; dec_i = 1'b0; sec_upd_i = 40; sub_upd_i = 32'h7FFF_FED4; cmd(1, 0, 0); run(6);
    // R10, R3: fine mode
    tag = "R10"; addend_stage_i = 32'h4000_0000; cmd(0, 0, 1); run(2);
    tag = "R3"; fine_i = 1'b1; run(40);
    addend_stage_i = 32'd3; cmd(0, 0, 1); run(12);
    fine_i = 1'b0; dec_i = 1'b1;
    // R8: additive steps, with and without wrap
    tag = "R8"; sec_upd_i = 100; sub_upd_i = 500_000_000; cmd(1, 0, 0); run(1);
    sec_upd_i = 2; sub_upd_i = 600_000_000; cmd(0, 1, 0); run(2);
    sec_upd_i = 1; sub_upd_i = 1_000; cmd(0, 1, 0); run(2);
    // R9: subtractive steps (3 s 200 ns, then 1 s 0.9 s)
    tag = "R9"; sec_upd_i = 10; sub_upd_i = 100; cmd(1, 0, 0); run(1);
    sec_upd_i = 32'hFFFF_FFFD; sub_upd_i = 32'h8000_0000 | 32'(1_000_000_000 - 200); cmd(0, 1, 0); run(2);
    sec_upd_i = 32'hFFFF_FFFF; sub_upd_i = 32'h8000_0000 | 32'(100_000_000); cmd(0, 1, 0); run(2);
    // R11: priority
    tag = "R11"; sec_upd_i = 77; sub_upd_i = 123; addend_stage_i = 32'h1234_5678;
    cmd(1, 1, 1); run(2);
    sec_upd_i = 3; sub_upd_i = 5; cmd(0, 1, 1); run(2);
    // R13: second write while pending
    tag = "R13"; @(negedge clk_i);
    cmd_wr_i = 1; cmd_step_i = 1;
    @(negedge clk_i);
    cmd_step_i = 0; cmd_reload_i = 1; addend_stage_i = 32'hDEAD_0001;
    @(negedge clk_i);
    cmd_wr_i = 0; cmd_reload_i = 0; run(3);
    // R12: disabled
    tag = "R12"; en_i = 1'b0; sec_upd_i = 9; sub_upd_i = 9; cmd(1, 0, 0); run(4);
    fine_i = 1'b1; run(3); fine_i = 1'b0;
    en_i = 1'b1; run(4);
    summary();
  end
endmodule